// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block runs the entry sequence of a 32-bit processor core when control leaves the running program. It arbitrates among three causes: a fast interrupt, a normal prioritised interrupt and a synchronous exception or unconditional trap. When a cause is accepted, the block saves the stack pointer that general register 0 currently stands for. It then captures the status word, saves the return state, finds the handler address and hands the core a new PC, a new status word and updated stack pointers in one commit cycle.

The fast class keeps its return state in two backup registers and takes its handler address from a dedicated register, so it never touches memory. The normal class and the exception class push the status word and then the PC onto the interrupt stack through a 32-bit request/acknowledge memory port. They then load the handler address from a relocatable table or, for low exception vectors, from a fixed table near the top of the address space. Interrupt entries end with a one-cycle acknowledge that carries the interrupt number. Any entry also produces a wake pulse, which takes the core out of its sleep state.

Top module: `irq_entry_ctrl`

## Requirements
- R1: The status word has its interrupt-enable flag at bit 16, its user-stack flag at bit 17, its privilege-mode flag at bit 20 and its priority level at bits 27:24. A normal request is taken only when the enable flag is 1 and the current level is strictly less than the requested level. Otherwise it leaves `busy`, `done` and the memory port idle.
- R2: A fast request is taken only when the enable flag is 1 and the current level is not 15.
- R3: When more than one cause is eligible in the same cycle, the fast interrupt wins over the normal one, and the normal one wins over an exception.
- R4: At acceptance, `r0_in` is taken as the user stack pointer when the user-stack flag is 1, and as the interrupt stack pointer otherwise. The other pointer keeps its input value. `usp_out` reports the resulting user stack pointer.
- R5: The committed status word equals the captured one with the enable, user-stack and privilege-mode flags cleared. Its level is 15 for a fast entry, the accepted level for a normal entry, and unchanged for an exception.
- R6: A fast entry writes PC to `bpc_out` and the captured status to `bstatus_out`, takes the new PC from `fvec_in`, and makes no memory access. Its `done` comes two cycles after the request edge.
- R7: A normal or exception entry stores the status word at ISP-4 and then the PC at ISP-8, in that order. It then loads the new PC with one read, and `isp_out` is ISP-8.
- R8: The handler address of a normal interrupt is `tbase_in` + 4·number. For an exception vector below 0x100 it is 0xFFFFFF80 + 4·vector. For vectors 0x100 to 0x1FF it is `tbase_in` + 4·(vector mod 256).
- R9: At commit, `r0_out` equals the final interrupt stack pointer. `wake` pulses for one cycle at acceptance.
- R10: `ack_valid` is a one-cycle pulse, raised together with `done`, only for interrupt entries. `ack_num` carries the accepted interrupt number, taken from `fst_num` for fast entries.
- R11: `busy` stays high from acceptance until commit, and requests seen while `busy` is high are dropped. The memory request, address and data hold steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nrm_req | input | 1 | Normal interrupt pending |
| nrm_num | input | 8 | Normal interrupt number |
| nrm_lvl | input | 4 | Normal interrupt priority level |
| fst_req | input | 1 | Fast interrupt pending |
| fst_num | input | 8 | Number reported on acknowledge of a fast entry |
| exc_req | input | 1 | Exception or trap pending |
| exc_vec | input | 9 | Exception vector (0x100 and above are traps) |
| status_in | input | 32 | Current status word |
| pc_in | input | 32 | Current PC |
| r0_in | input | 32 | General register 0 |
| usp_in | input | 32 | Current user stack pointer |
| isp_in | input | 32 | Current interrupt stack pointer |
| tbase_in | input | 32 | Relocatable vector table base |
| fvec_in | input | 32 | Fast interrupt handler address |
| busy | output | 1 | Entry sequence in progress |
| wake | output | 1 | One-cycle pulse at acceptance, clears sleep |
| done | output | 1 | One-cycle pulse at commit |
| pc_out | output | 32 | Handler PC |
| status_out | output | 32 | New status word |
| r0_out | output | 32 | New register 0 value |
| usp_out | output | 32 | New user stack pointer |
| isp_out | output | 32 | New interrupt stack pointer |
| bpc_out | output | 32 | Backup PC (fast entries) |
| bstatus_out | output | 32 | Backup status word (fast entries) |
| ack_valid | output | 1 | Interrupt acknowledge pulse |
| ack_num | output | 8 | Acknowledged interrupt number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a store |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory access completed |
| mem_rdata | input | 32 | Load data, valid with mem_ack |

## Verification
Acceptance happens at the first clock edge that sees a request, so `busy` and `wake` are high in the following cycle. A fast entry commits one edge later, so `done`, `ack_valid` and all committed values appear two cycles after the request edge. A stack-based entry issues three accesses, and each takes L+1 cycles when memory acknowledges after L wait cycles. Its commit therefore appears 3(L+1)+1 cycles after the request edge. The bench drives inputs and samples on the falling edge. It counts falling edges from the request and requires `done` at exactly that count. It checks every committed value and the logged store and load addresses at that sample, and for rejected or dropped requests it watches `busy` and `done` over the cycles in which a wrongful acceptance would show.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FAST    = 3'd1,
    ST_PUSH_SR = 3'd2,
    ST_PUSH_PC = 3'd3,
    ST_FETCH   = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_FAST = 2'd1,
    KIND_NORM = 2'd2,
    KIND_EXC  = 2'd3
  } entry_kind_t;

  // status word field positions
  localparam int SR_EN_BIT  = 16;
  localparam int SR_US_BIT  = 17;
  localparam int SR_PM_BIT  = 20;
  localparam int SR_LVL_LSB = 24;

  // well-known exception vector numbers
  localparam logic [8:0] VEC_PRIV_FAULT  = 9'd20;
  localparam logic [8:0] VEC_ACCESS      = 9'd21;
  localparam logic [8:0] VEC_UNDEF_OP    = 9'd23;
  localparam logic [8:0] VEC_FP_FAULT    = 9'd25;
  localparam logic [8:0] VEC_NMI         = 9'd30;

endpackage

// File: rtl/irq_accept.sv
module irq_accept
  import irq_entry_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             fast_req,
  input  logic             norm_req,
  input  logic             exc_req,
  input  logic             en_flag,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic [LVL_W-1:0] req_lvl,
  output entry_kind_t      kind
);
  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

  logic fast_ok;
  logic norm_ok;

  assign fast_ok = fast_req && en_flag && (cur_lvl != LVL_TOP);
  assign norm_ok = norm_req && en_flag && (cur_lvl < req_lvl);

  always_comb begin
    if (fast_ok)      kind = KIND_FAST;
    else if (norm_ok) kind = KIND_NORM;
    else if (exc_req) kind = KIND_EXC;
    else              kind = KIND_NONE;
  end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr
  import irq_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NUM_W      = 8,
  parameter int              VEC_W      = 9,
  parameter logic [XLEN-1:0] FIXED_BASE = 32'hFFFF_FF80
) (
  input  entry_kind_t      kind,
  input  logic [NUM_W-1:0] num,
  input  logic [VEC_W-1:0] vec,
  input  logic [XLEN-1:0]  tbase,
  output logic [XLEN-1:0]  addr
);
  localparam int PAD_N = XLEN - NUM_W - 2;
  localparam int PAD_V = XLEN - VEC_W - 2;

  logic [XLEN-1:0] num_off;
  logic [XLEN-1:0] vec_off;
  logic [XLEN-1:0] trap_off;

  assign num_off  = {{PAD_N{1'b0}}, num, 2'b00};
  assign vec_off  = {{PAD_V{1'b0}}, vec, 2'b00};
  assign trap_off = {{PAD_N{1'b0}}, vec[NUM_W-1:0], 2'b00};

  always_comb begin
    if (kind == KIND_EXC) begin
      if (vec[VEC_W-1]) addr = tbase + trap_off;
      else              addr = FIXED_BASE + vec_off;
    end else begin
      addr = tbase + num_off;
    end
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NUM_W      = 8,
  parameter int              LVL_W      = 4,
  parameter int              VEC_W      = 9,
  parameter logic [XLEN-1:0] FIXED_BASE = 32'hFFFF_FF80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nrm_req,
  input  logic [NUM_W-1:0] nrm_num,
  input  logic [LVL_W-1:0] nrm_lvl,
  input  logic             fst_req,
  input  logic [NUM_W-1:0] fst_num,
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_vec,
  input  logic [XLEN-1:0]  status_in,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  r0_in,
  input  logic [XLEN-1:0]  usp_in,
  input  logic [XLEN-1:0]  isp_in,
  input  logic [XLEN-1:0]  tbase_in,
  input  logic [XLEN-1:0]  fvec_in,
  output logic             busy,
  output logic             wake,
  output logic             done,
  output logic [XLEN-1:0]  pc_out,
  output logic [XLEN-1:0]  status_out,
  output logic [XLEN-1:0]  r0_out,
  output logic [XLEN-1:0]  usp_out,
  output logic [XLEN-1:0]  isp_out,
  output logic [XLEN-1:0]  bpc_out,
  output logic [XLEN-1:0]  bstatus_out,
  output logic             ack_valid,
  output logic [NUM_W-1:0] ack_num,
  output logic             mem_req,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic             mem_ack,
  input  logic [XLEN-1:0]  mem_rdata
);
  localparam logic [XLEN-1:0]  WORD_BYTES = XLEN'(4);
  localparam logic [LVL_W-1:0] LVL_TOP    = {LVL_W{1'b1}};
  localparam logic [XLEN-1:0]  CLR_MASK   =
    ~((XLEN'(1) << SR_EN_BIT) | (XLEN'(1) << SR_US_BIT) | (XLEN'(1) << SR_PM_BIT));
  localparam logic [XLEN-1:0]  LVL_MASK   = ~(XLEN'({LVL_W{1'b1}}) << SR_LVL_LSB);

  // sequencer state and captured context
  seq_state_t       state_q,  state_d;
  entry_kind_t      kind_q,   kind_d;
  logic [XLEN-1:0]  sr_q,     sr_d;
  logic [XLEN-1:0]  pc_q,     pc_d;
  logic [XLEN-1:0]  isp_q,    isp_d;
  logic [XLEN-1:0]  usp_q,    usp_d;
  logic [XLEN-1:0]  vadr_q,   vadr_d;
  logic [NUM_W-1:0] num_q,    num_d;
  logic [LVL_W-1:0] lvl_q,    lvl_d;

  // committed outputs
  logic             wake_d, done_d, ack_d;
  logic [NUM_W-1:0] ackn_d;
  logic [XLEN-1:0]  pco_d, sro_d, r0o_d, uspo_d, ispo_d, bpc_d, bsr_d;

  entry_kind_t      sel_kind;
  logic [XLEN-1:0]  sel_addr;
  logic [NUM_W-1:0] sel_num;
  logic [LVL_W-1:0] cur_lvl;
  logic             cur_en;
  logic             cur_us;
  logic             commit;

  assign cur_lvl = status_in[SR_LVL_LSB +: LVL_W];
  assign cur_en  = status_in[SR_EN_BIT];
  assign cur_us  = status_in[SR_US_BIT];

  irq_accept #(.LVL_W(LVL_W)) accept_i (
    .fast_req (fst_req),
    .norm_req (nrm_req),
    .exc_req  (exc_req),
    .en_flag  (cur_en),
    .cur_lvl  (cur_lvl),
    .req_lvl  (nrm_lvl),
    .kind     (sel_kind)
  );

  assign sel_num = (sel_kind == KIND_FAST) ? fst_num :
                   (sel_kind == KIND_NORM) ? nrm_num : exc_vec[NUM_W-1:0];

  irq_vec_addr #(
    .XLEN(XLEN), .NUM_W(NUM_W), .VEC_W(VEC_W), .FIXED_BASE(FIXED_BASE)
  ) vaddr_i (
    .kind  (sel_kind),
    .num   (nrm_num),
    .vec   (exc_vec),
    .tbase (tbase_in),
    .addr  (sel_addr)
  );

  // memory port, driven from registered state
  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC) || (state_q == ST_FETCH);
  assign mem_we    = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC);
  assign mem_addr  = (state_q == ST_FETCH) ? vadr_q : (isp_q - WORD_BYTES);
  assign mem_wdata = (state_q == ST_PUSH_SR) ? sr_q : pc_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    sr_d    = sr_q;
    pc_d    = pc_q;
    isp_d   = isp_q;
    usp_d   = usp_q;
    vadr_d  = vadr_q;
    num_d   = num_q;
    lvl_d   = lvl_q;
    wake_d  = 1'b0;
    done_d  = 1'b0;
    ack_d   = 1'b0;
    ackn_d  = ack_num;
    pco_d   = pc_out;
    sro_d   = status_out;
    r0o_d   = r0_out;
    uspo_d  = usp_out;
    ispo_d  = isp_out;
    bpc_d   = bpc_out;
    bsr_d   = bstatus_out;
    commit  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (sel_kind != KIND_NONE) begin
          wake_d = 1'b1;
          kind_d = sel_kind;
          sr_d   = status_in;
          pc_d   = pc_in;
          isp_d  = cur_us ? isp_in : r0_in;
          usp_d  = cur_us ? r0_in : usp_in;
          vadr_d = sel_addr;
          num_d  = sel_num;
          unique case (sel_kind)
            KIND_FAST: lvl_d = LVL_TOP;
            KIND_NORM: lvl_d = nrm_lvl;
            default:   lvl_d = cur_lvl;
          endcase
          state_d = (sel_kind == KIND_FAST) ? ST_FAST : ST_PUSH_SR;
        end
      end
      ST_FAST: begin
        bpc_d  = pc_q;
        bsr_d  = sr_q;
        pco_d  = fvec_in;
        commit = 1'b1;
      end
      ST_PUSH_SR: begin
        if (mem_ack) begin
          isp_d   = isp_q - WORD_BYTES;
          state_d = ST_PUSH_PC;
        end
      end
      ST_PUSH_PC: begin
        if (mem_ack) begin
          isp_d   = isp_q - WORD_BYTES;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          pco_d  = mem_rdata;
          commit = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (commit) begin
      state_d = ST_IDLE;
      sro_d   = (sr_q & CLR_MASK & LVL_MASK) | (XLEN'(lvl_q) << SR_LVL_LSB);
      ispo_d  = isp_q;
      r0o_d   = isp_q;
      uspo_d  = usp_q;
      done_d  = 1'b1;
      ack_d   = (kind_q != KIND_EXC);
      ackn_d  = num_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      kind_q      <= KIND_NONE;
      sr_q        <= '0;
      pc_q        <= '0;
      isp_q       <= '0;
      usp_q       <= '0;
      vadr_q      <= '0;
      num_q       <= '0;
      lvl_q       <= '0;
      wake        <= 1'b0;
      done        <= 1'b0;
      ack_valid   <= 1'b0;
      ack_num     <= '0;
      pc_out      <= '0;
      status_out  <= '0;
      r0_out      <= '0;
      usp_out     <= '0;
      isp_out     <= '0;
      bpc_out     <= '0;
      bstatus_out <= '0;
    end else begin
      state_q     <= state_d;
      kind_q      <= kind_d;
      sr_q        <= sr_d;
      pc_q        <= pc_d;
      isp_q       <= isp_d;
      usp_q       <= usp_d;
      vadr_q      <= vadr_d;
      num_q       <= num_d;
      lvl_q       <= lvl_d;
      wake        <= wake_d;
      done        <= done_d;
      ack_valid   <= ack_d;
      ack_num     <= ackn_d;
      pc_out      <= pco_d;
      status_out  <= sro_d;
      r0_out      <= r0o_d;
      usp_out     <= uspo_d;
      isp_out     <= ispo_d;
      bpc_out     <= bpc_d;
      bstatus_out <= bsr_d;
    end
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
  import irq_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            wake,
  input logic            done,
  input logic            ack_valid,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic [XLEN-1:0] status_out,
  input logic [XLEN-1:0] r0_out,
  input logic [XLEN-1:0] isp_out
);
  AST_MEM_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R11

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !ack_valid); // R10

  AST_ACK_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> done); // R10

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!status_out[SR_EN_BIT] && !status_out[SR_US_BIT] && !status_out[SR_PM_BIT])); // R5

  AST_R0_MIRRORS_ISP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (r0_out == isp_out)); // R9

  AST_WAKE_STARTS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> busy); // R9

  AST_DONE_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
endmodule

bind irq_entry_ctrl irq_entry_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .wake       (wake),
  .done       (done),
  .ack_valid  (ack_valid),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .status_out (status_out),
  .r0_out     (r0_out),
  .isp_out    (isp_out)
);

// File: tb/irq_entry_ctrl_tb.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nrm_req, fst_req, exc_req;
  logic [7:0]  nrm_num, fst_num;
  logic [3:0]  nrm_lvl;
  logic [8:0]  exc_vec;
  logic [31:0] status_in, pc_in, r0_in, usp_in, isp_in, tbase_in, fvec_in;
  logic        busy, wake, done, ack_valid;
  logic [31:0] pc_out, status_out, r0_out, usp_out, isp_out, bpc_out, bstatus_out;
  logic [7:0]  ack_num;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  irq_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .nrm_req(nrm_req), .nrm_num(nrm_num), .nrm_lvl(nrm_lvl),
    .fst_req(fst_req), .fst_num(fst_num),
    .exc_req(exc_req), .exc_vec(exc_vec),
    .status_in(status_in), .pc_in(pc_in), .r0_in(r0_in),
    .usp_in(usp_in), .isp_in(isp_in), .tbase_in(tbase_in), .fvec_in(fvec_in),
    .busy(busy), .wake(wake), .done(done),
    .pc_out(pc_out), .status_out(status_out), .r0_out(r0_out),
    .usp_out(usp_out), .isp_out(isp_out), .bpc_out(bpc_out), .bstatus_out(bstatus_out),
    .ack_valid(ack_valid), .ack_num(ack_num),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: acknowledges after lat wait cycles, logs every access
  int          lat = 0;
  int          wcnt = 0;
  int          n_wr = 0;
  int          n_rd = 0;
  logic [31:0] wa [4];
  logic [31:0] wd [4];
  logic [31:0] ra;

  function automatic logic [31:0] rd_pattern(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) wcnt = 0;
    mem_ack = 1'b0;
    if (mem_req) begin
      if (wcnt == lat) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          wa[n_wr % 4] = mem_addr;
          wd[n_wr % 4] = mem_wdata;
          n_wr++;
        end else begin
          ra = mem_addr;
          mem_rdata = rd_pattern(mem_addr);
          n_rd++;
        end
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_status(input logic [3:0] lvl, input bit en,
                                            input bit us, input bit pm);
    return 32'h0000_000F | (32'(lvl) << 24) | (32'(en) << 16) | (32'(us) << 17) | (32'(pm) << 20);
  endfunction

  // one entry attempt; expected results computed from the requirements
  task automatic run_case(input bit fq, input bit nq, input bit eq,
                          input logic [7:0] nnum, input logic [3:0] nlvl,
                          input logic [8:0] vec, input logic [31:0] sr,
                          input int latency, input bit pester);
    int          cls;
    int          base_w, base_r, cyc;
    logic [3:0]  cur;
    bit          en, us;
    logic [31:0] isp0, usp0, exp_pc, exp_sr, vaddr, new_lvl;
    logic [7:0]  exp_num;
    bit          seen;
    cur = sr[27:24];
    en  = sr[16];
    us  = sr[17];
    if (fq && en && cur != 4'd15)  cls = 1;   // R2, R3
    else if (nq && en && cur < nlvl) cls = 2; // R1, R3
    else if (eq) cls = 3;
    else cls = 0;

    @(negedge clk);
    lat       = latency;
    status_in = sr;
    pc_in     = 32'h0001_2340 + 32'(nnum);
    r0_in     = 32'h0000_8000 + 32'(nnum) * 16;
    usp_in    = 32'h0000_6000;
    isp_in    = 32'h0000_7000;
    tbase_in  = 32'h0004_0000;
    fvec_in   = 32'h000F_F000 + 32'(vec);
    nrm_num   = nnum;
    nrm_lvl   = nlvl;
    fst_num   = ~nnum;
    exc_vec   = vec;
    nrm_req   = nq;
    fst_req   = fq;
    exc_req   = eq;
    base_w    = n_wr;
    base_r    = n_rd;
    @(negedge clk);
    nrm_req = 1'b0;
    fst_req = 1'b0;
    exc_req = 1'b0;

    if (cls == 0) begin
      seen = busy || done || mem_req;
      @(negedge clk);
      seen = seen || busy || done || mem_req;
      chk(!seen, "R1", "rejected request started a sequence", 32'(seen), 32'd0);
      return;
    end

    chk(wake && busy, "R9", "wake/busy after acceptance", {30'd0, wake, busy}, 32'd3);
    cyc = 0;
    while (!done && cyc < 40) begin
      if (pester && busy) begin
        nrm_req = 1'b1;
        nrm_lvl = 4'd15;
        fst_req = 1'b1;
      end
      @(negedge clk);
      nrm_req = 1'b0;
      fst_req = 1'b0;
      cyc++;
    end

    isp0 = us ? 32'h0000_7000 : r0_in;
    usp0 = us ? r0_in : 32'h0000_6000;
    new_lvl = (cls == 1) ? 32'd15 : (cls == 2) ? 32'(nlvl) : 32'(cur);
    exp_sr = (sr & ~32'h0013_0000 & ~32'h0F00_0000) | (new_lvl << 24);
    chk(usp_out == usp0, "R4", "usp_out", usp_out, usp0);
    chk(status_out == exp_sr, "R5", "status_out", status_out, exp_sr);

    if (cls == 1) begin
      chk(cyc == 1, "R6", "fast done latency", 32'(cyc), 32'd1);
      chk(n_wr == base_w && n_rd == base_r, "R6", "fast memory accesses",
          32'(n_wr - base_w + n_rd - base_r), 32'd0);
      chk(bpc_out == pc_in, "R6", "bpc_out", bpc_out, pc_in);
      chk(bstatus_out == sr, "R6", "bstatus_out", bstatus_out, sr);
      chk(pc_out == fvec_in, "R6", "pc_out", pc_out, fvec_in);
      chk(isp_out == isp0 && r0_out == isp0, "R9", "isp/r0 after fast", r0_out, isp0);
      exp_num = ~nnum;
    end else begin
      if (cls == 2) vaddr = 32'h0004_0000 + 32'(nnum) * 4;
      else if (vec < 9'h100) vaddr = 32'hFFFF_FF80 + 32'(vec) * 4;
      else vaddr = 32'h0004_0000 + 32'(vec[7:0]) * 4;
      exp_pc = rd_pattern(vaddr);
      chk(cyc == 3 + 3 * latency, "R7", "stack entry latency", 32'(cyc), 32'(3 + 3 * latency));
      chk(n_wr - base_w == 2 && n_rd - base_r == 1, "R7", "access count",
          32'(n_wr - base_w) * 16 + 32'(n_rd - base_r), 32'h21);
      chk(wa[base_w % 4] == isp0 - 4 && wd[base_w % 4] == sr, "R7", "status push",
          wa[base_w % 4], isp0 - 4);
      chk(wa[(base_w + 1) % 4] == isp0 - 8 && wd[(base_w + 1) % 4] == pc_in, "R7", "PC push",
          wa[(base_w + 1) % 4], isp0 - 8);
      chk(ra == vaddr, "R8", "vector address", ra, vaddr);
      chk(pc_out == exp_pc, "R8", "handler pc", pc_out, exp_pc);
      chk(isp_out == isp0 - 8, "R7", "isp_out", isp_out, isp0 - 8);
      chk(r0_out == isp0 - 8, "R9", "r0_out", r0_out, isp0 - 8);
      exp_num = nnum;
    end

    if (cls == 3) chk(!ack_valid, "R10", "ack on exception", 32'(ack_valid), 32'd0);
    else chk(ack_valid && ack_num == exp_num, "R10", "ack_num", {23'd0, ack_valid, ack_num},
             {23'd1, exp_num});

    @(negedge clk);
    chk(!ack_valid && !done, "R10", "ack/done one cycle", {30'd0, ack_valid, done}, 32'd0);
    if (pester) begin
      seen = busy;
      @(negedge clk);
      seen = seen || busy;
      chk(!seen, "R11", "request while busy was kept", 32'(seen), 32'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    nrm_req = 1'b0; fst_req = 1'b0; exc_req = 1'b0;
    nrm_num = '0; nrm_lvl = '0; fst_num = '0; exc_vec = '0;
    status_in = '0; pc_in = '0; r0_in = '0; usp_in = '0; isp_in = '0;
    tbase_in = '0; fvec_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ack_valid && !mem_req && !wake, "R11", "reset state",
        {27'd0, busy, done, ack_valid, mem_req, wake}, 32'd0);
    rst_n = 1'b1;

    // R1: normal acceptance sweep over level pairs, enable and stack flag
    for (int en = 0; en < 2; en++)
      for (int c = 0; c < 16; c++)
        for (int l = 0; l < 16; l++)
          run_case(1'b0, 1'b1, 1'b0, 8'(l * 16 + c), 4'(l), 9'd0,
                   mk_status(4'(c), en[0], l[0], c[0]), (c + l) % 3, 1'b0);

    // R2: fast acceptance sweep
    for (int en = 0; en < 2; en++)
      for (int c = 0; c < 16; c++)
        run_case(1'b1, 1'b0, 1'b0, 8'(c + 100), 4'd0, 9'd7,
                 mk_status(4'(c), en[0], c[1], c[0]), 0, 1'b0);

    // R3: every combination of pending causes
    for (int m = 1; m < 8; m++)
      run_case(m[0], m[1], m[2], 8'(m + 40), 4'd9, 9'd23,
               mk_status(4'd3, 1'b1, m[0], 1'b1), 1, 1'b0);

    // R8: exception and trap vectors, including table edges
    begin
      logic [8:0] vl [12];
      vl = '{9'd20, 9'd21, 9'd23, 9'd25, 9'd30, 9'h000, 9'h0FF,
             9'h100, 9'h1AB, 9'h1FF, 9'h180, 9'h07F};
      for (int i = 0; i < 12; i++)
        run_case(1'b0, 1'b0, 1'b1, 8'(i), 4'd0, vl[i],
                 mk_status(4'(i), i[0], i[1], i[2]), i % 3, 1'b0);
    end

    // R11: requests raised while busy are dropped
    run_case(1'b0, 1'b1, 1'b0, 8'h33, 4'd8, 9'd0, mk_status(4'd2, 1'b1, 1'b0, 1'b0), 2, 1'b1);
    run_case(1'b0, 1'b0, 1'b1, 8'h34, 4'd0, 9'd30, mk_status(4'd1, 1'b1, 1'b1, 1'b0), 0, 1'b1);
    run_case(1'b1, 1'b0, 1'b0, 8'h35, 4'd0, 9'd0, mk_status(4'd0, 1'b1, 1'b0, 1'b1), 0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule